// File: doc/BRIEF.md
# Byte-Serial Market Feed Message Normalizer

This block sits behind a packet layer that has already stripped the network and transport headers. It takes the payload one byte per clock: a chain of binary market data messages placed end to end. For each message it learns the length and the type, picks the fields out of the bytes that follow, and turns the message into one fixed-width order book command. The command carries a kind code, side, three quantities, a price, an eight-character symbol and a 64-bit order id.

Four message kinds are understood: a long add-order (type 0x21), a short add-order (type 0x22), an execution (type 0x23) and a cancel (type 0x24). Any other type is passed over using its length byte, and the following byte is read as the next length. The short add-order uses narrower quantity and price fields. The block widens them into the same record, and it rescales the price so that both add-order forms give one price unit.

The input has a valid strobe, and the block drives a ready back to the source. The output has a valid strobe, and the consumer drives a ready back to the block. When a finished command is not taken, the block stops accepting input bytes until the consumer takes it.

Top module: `mdfeed_normalizer`

## Requirements
- R1: When `rst` is high at a clock edge, the block clears all of its parse state. After reset, `cmd_valid` is low, `in_ready` is high and the next accepted byte is taken as a length.
- R2: A byte is accepted when `in_valid` and `in_ready` are both high. Within a message, byte index 0 is the length (total bytes, the length byte included) and index 1 is the type. The message ends on the byte at index length−1. A length below 2 ends the message on the type byte. The byte after the end is the next length.
- R3: Type 0x21 gives `cmd_code` 1 (add). The order id is at bytes 6–13, the side at byte 14, the quantity at bytes 15–18, the symbol at bytes 19–24 and the 64-bit price at bytes 25–32.
- R4: Type 0x22 gives `cmd_code` 1. The order id is at bytes 6–13 and the side at byte 14. The 16-bit quantity at bytes 15–16 is zero-extended to 32 bits. The symbol is at bytes 17–22. The 16-bit price at bytes 23–24 is multiplied by 100 to give the price in long-form units.
- R5: Type 0x23 gives `cmd_code` 2 (execute). The order id is at bytes 6–13 and the executed quantity at bytes 14–17.
- R6: Type 0x24 gives `cmd_code` 3 (cancel). The order id is at bytes 6–13 and the cancelled quantity at bytes 14–17.
- R7: Every multi-byte numeric field is little-endian: the first byte received is the least significant byte.
- R8: Symbol character i sits at `cmd_symbol` bits 8i+7..8i, and character 0 is the first byte received. Characters 6 and 7 are always the space code 0x20.
- R9: A command field that the message type does not carry reads as zero, except the symbol, which reads as eight spaces. Nothing from an earlier message remains in it.
- R10: A message of any other type yields no command. All of its bytes are still consumed.
- R11: `cmd_valid` rises on the clock after the final byte of a known message is accepted. It stays high until a cycle with `cons_ready` high, and it falls after that cycle. While it waits, every command field stays stable and `in_ready` is low.
- R12: While `cons_ready` is held high, `in_ready` never drops. Commands for messages sent back to back are all delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Payload byte |
| in_valid | input | 1 | `in_byte` holds a byte this cycle |
| in_ready | output | 1 | Block can take a byte this cycle |
| cons_ready | input | 1 | Consumer can take a command this cycle |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 2 | 0 none, 1 add, 2 execute, 3 cancel |
| cmd_side | output | 8 | Side character (0x42 buy, 0x53 sell) |
| cmd_qty | output | 32 | Order quantity |
| cmd_exec_qty | output | 32 | Executed quantity |
| cmd_cancel_qty | output | 32 | Cancelled quantity |
| cmd_price | output | 64 | Price in long-form units |
| cmd_symbol | output | 64 | Eight-character symbol, space padded |
| cmd_order_id | output | 64 | Order id |

## Verification
In one clock cycle the consumer can take the pending command while the same edge accepts the length byte of the next message. That same edge also clears the field record for the new message. The bench provokes this by sending messages with no gap while `cons_ready` stays high. It then requires that `in_ready` never dropped, that the scoreboard received every command with its own field values, and that the fields of one message never reach the next. A held-low consumer and a throttled consumer cover the opposite case, where the end of a message must wait behind a command not yet taken.

// File: rtl/mdn_pkg.sv
package mdn_pkg;

  localparam int BYTE_W     = 8;
  localparam int QTY_W      = 32;
  localparam int PRICE_W    = 64;
  localparam int OID_W      = 64;
  localparam int SYM_CHARS  = 8;
  localparam int SYM_W      = SYM_CHARS * BYTE_W;
  localparam int WIRE_SYM_N = 6;
  localparam int OID_N      = OID_W / BYTE_W;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_ADD    = 2'd1,
    CMD_EXEC   = 2'd2,
    CMD_CANCEL = 2'd3
  } cmd_e;

  localparam logic [7:0] T_ADD_LONG  = 8'h21;
  localparam logic [7:0] T_ADD_SHORT = 8'h22;
  localparam logic [7:0] T_EXEC      = 8'h23;
  localparam logic [7:0] T_CANCEL    = 8'h24;
  localparam logic [7:0] PAD_CHAR    = 8'h20;

  // Byte offsets inside a message; field positions drive the decode.
  localparam int OFS_OID     = 6;
  localparam int OFS_SIDE    = 14;
  localparam int OFS_QTY     = 15;
  localparam int OFS_XQTY    = 14;
  localparam int L_OFS_SYM   = 19;
  localparam int L_OFS_PRICE = 25;
  localparam int S_OFS_SYM   = 17;
  localparam int S_OFS_PRICE = 23;

  function automatic cmd_e decode_type(input logic [7:0] t);
    case (t)
      T_ADD_LONG, T_ADD_SHORT: return CMD_ADD;
      T_EXEC:                  return CMD_EXEC;
      T_CANCEL:                return CMD_CANCEL;
      default:                 return CMD_NONE;
    endcase
  endfunction

  function automatic logic in_span(input logic [7:0] idx, input int start, input int n);
    return (int'(idx) >= start) && (int'(idx) < start + n);
  endfunction

  function automatic logic [2:0] lane(input logic [7:0] idx, input int start);
    int d;
    d = int'(idx) - start;
    return d[2:0];
  endfunction

  function automatic logic [SYM_W-1:0] blank_symbol();
    return {SYM_CHARS{PAD_CHAR}};
  endfunction

  function automatic logic [PRICE_W-1:0] scale_price(input logic [15:0] raw, input int unsigned k);
    return PRICE_W'(raw) * PRICE_W'(k);
  endfunction

endpackage

// File: rtl/mdn_byte_tracker.sv
module mdn_byte_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       din,
  input  logic             in_valid,
  input  logic             in_ready,
  output logic             accept,
  output logic [CNT_W-1:0] cnt,
  output logic             first_byte,
  output logic             type_byte,
  output logic             msg_end,
  output logic [7:0]       type_q
);

  localparam int CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] len_q;

  assign accept     = in_valid && in_ready;
  assign first_byte = (cnt == '0);
  assign type_byte  = (cnt == CNT_W'(1));
  assign msg_end    = accept && !first_byte &&
                      (({1'b0, cnt} + CMP_W'(1)) >= CMP_W'(len_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      len_q  <= '0;
      type_q <= '0;
    end else if (accept) begin
      if (first_byte) len_q  <= CNT_W'(din);
      if (type_byte)  type_q <= din;
      cnt <= msg_end ? '0 : cnt + CNT_W'(1);
    end
  end

  assert_end_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    msg_end |=> (cnt == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !msg_end) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(cnt));

endmodule

// File: rtl/mdn_field_assembler.sv
module mdn_field_assembler
  import mdn_pkg::*;
#(
  parameter int unsigned PRICE_SCALE = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               first_byte,
  input  logic               type_byte,
  input  logic [7:0]         cnt,
  input  logic [7:0]         din,
  input  logic [7:0]         type_q,
  output cmd_e               code_now,
  output cmd_e               code_q,
  output logic [7:0]         side_q,
  output logic [QTY_W-1:0]   qty_q,
  output logic [QTY_W-1:0]   xqty_q,
  output logic [QTY_W-1:0]   cqty_q,
  output logic [PRICE_W-1:0] price_o,
  output logic [SYM_W-1:0]   sym_q,
  output logic [OID_W-1:0]   oid_q
);

  logic               short_q;
  logic [PRICE_W-1:0] price_q;

  assign code_now = type_byte ? decode_type(din) : code_q;
  assign price_o  = short_q ? scale_price(price_q[15:0], PRICE_SCALE) : price_q;

  always_ff @(posedge clk) begin
    if (rst || (accept && first_byte)) begin
      code_q  <= CMD_NONE;
      short_q <= 1'b0;
      side_q  <= '0;
      qty_q   <= '0;
      xqty_q  <= '0;
      cqty_q  <= '0;
      price_q <= '0;
      sym_q   <= blank_symbol();
      oid_q   <= '0;
    end else if (accept && type_byte) begin
      code_q  <= decode_type(din);
      short_q <= (din == T_ADD_SHORT);
    end else if (accept) begin
      if (in_span(cnt, OFS_OID, OID_N) && (decode_type(type_q) != CMD_NONE))
        oid_q[8*lane(cnt, OFS_OID) +: 8] <= din;
      case (type_q)
        T_ADD_LONG: begin
          if (int'(cnt) == OFS_SIDE)               side_q <= din;
          if (in_span(cnt, OFS_QTY, 4))            qty_q[8*lane(cnt, OFS_QTY) +: 8] <= din;
          if (in_span(cnt, L_OFS_SYM, WIRE_SYM_N)) sym_q[8*lane(cnt, L_OFS_SYM) +: 8] <= din;
          if (in_span(cnt, L_OFS_PRICE, 8))        price_q[8*lane(cnt, L_OFS_PRICE) +: 8] <= din;
        end
        T_ADD_SHORT: begin
          if (int'(cnt) == OFS_SIDE)               side_q <= din;
          if (in_span(cnt, OFS_QTY, 2))            qty_q[8*lane(cnt, OFS_QTY) +: 8] <= din;
          if (in_span(cnt, S_OFS_SYM, WIRE_SYM_N)) sym_q[8*lane(cnt, S_OFS_SYM) +: 8] <= din;
          if (in_span(cnt, S_OFS_PRICE, 2))        price_q[8*lane(cnt, S_OFS_PRICE) +: 8] <= din;
        end
        T_EXEC: begin
          if (in_span(cnt, OFS_XQTY, 4)) xqty_q[8*lane(cnt, OFS_XQTY) +: 8] <= din;
        end
        T_CANCEL: begin
          if (in_span(cnt, OFS_XQTY, 4)) cqty_q[8*lane(cnt, OFS_XQTY) +: 8] <= din;
        end
        default: ;
      endcase
    end
  end

  assert_clear_on_length_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && first_byte) |=> (qty_q == '0 && xqty_q == '0 && cqty_q == '0 &&
                                oid_q == '0 && side_q == '0 && sym_q == blank_symbol()));

  assert_short_width_R4: assert property (@(posedge clk) disable iff (rst)
    (code_q == CMD_ADD && short_q) |-> (qty_q[31:16] == '0));

endmodule

// File: rtl/mdn_cmd_stage.sv
module mdn_cmd_stage
  import mdn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic msg_end,
  input  cmd_e code_now,
  input  logic cons_ready,
  output logic pend_q,
  output logic in_ready
);

  logic emit;

  assign emit     = msg_end && (code_now != CMD_NONE);
  assign in_ready = !pend_q || cons_ready;

  always_ff @(posedge clk) begin
    if (rst)             pend_q <= 1'b0;
    else if (emit)       pend_q <= 1'b1;
    else if (cons_ready) pend_q <= 1'b0;
  end

  assert_unknown_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_end && code_now == CMD_NONE) |=> !pend_q);

  assert_known_emits_R11: assert property (@(posedge clk) disable iff (rst)
    emit |=> pend_q);

  assert_hold_until_taken_R11: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !cons_ready) |=> pend_q);

  assert_drop_after_take_R11: assert property (@(posedge clk) disable iff (rst)
    (pend_q && cons_ready) |=> !pend_q);

endmodule

// File: rtl/mdfeed_normalizer.sv
module mdfeed_normalizer
  import mdn_pkg::*;
#(
  parameter int unsigned PRICE_SCALE = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [7:0]   in_byte,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         cons_ready,
  output logic         cmd_valid,
  output logic [1:0]   cmd_code,
  output logic [7:0]   cmd_side,
  output logic [31:0]  cmd_qty,
  output logic [31:0]  cmd_exec_qty,
  output logic [31:0]  cmd_cancel_qty,
  output logic [63:0]  cmd_price,
  output logic [63:0]  cmd_symbol,
  output logic [63:0]  cmd_order_id
);

  logic       accept;
  logic [7:0] cnt;
  logic       first_byte;
  logic       type_byte;
  logic       msg_end;
  logic [7:0] type_q;
  cmd_e       code_now;
  cmd_e       code_q;

  mdn_byte_tracker #(.CNT_W(8)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .din        (in_byte),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .accept     (accept),
    .cnt        (cnt),
    .first_byte (first_byte),
    .type_byte  (type_byte),
    .msg_end    (msg_end),
    .type_q     (type_q)
  );

  mdn_field_assembler #(.PRICE_SCALE(PRICE_SCALE)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .first_byte (first_byte),
    .type_byte  (type_byte),
    .cnt        (cnt),
    .din        (in_byte),
    .type_q     (type_q),
    .code_now   (code_now),
    .code_q     (code_q),
    .side_q     (cmd_side),
    .qty_q      (cmd_qty),
    .xqty_q     (cmd_exec_qty),
    .cqty_q     (cmd_cancel_qty),
    .price_o    (cmd_price),
    .sym_q      (cmd_symbol),
    .oid_q      (cmd_order_id)
  );

  mdn_cmd_stage u_cmd (
    .clk        (clk),
    .rst        (rst),
    .msg_end    (msg_end),
    .code_now   (code_now),
    .cons_ready (cons_ready),
    .pend_q     (cmd_valid),
    .in_ready   (in_ready)
  );

  assign cmd_code = code_q;

  assert_symbol_pad_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_symbol[63:48] == 16'h2020));

  assert_stall_fields_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cons_ready) |=> ($stable(cmd_order_id) && $stable(cmd_price) &&
                                    $stable(cmd_qty) && $stable(cmd_symbol) &&
                                    $stable(cmd_code) && $stable(cnt)));

endmodule

// File: tb/mdfeed_normalizer_bench.sv
module mdfeed_normalizer_bench;

  typedef struct {
    string       tag;
    logic [1:0]  code;
    logic [7:0]  side;
    logic [31:0] qty, xq, cq;
    logic [63:0] price, sym, oid;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        cons_ready = 1'b1;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [7:0]  cmd_side;
  logic [31:0] cmd_qty, cmd_exec_qty, cmd_cancel_qty;
  logic [63:0] cmd_price, cmd_symbol, cmd_order_id;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0, n_cmds = 0, n_sent_cmds = 0, stall_cycles = 0;
  int   cmode = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  mdfeed_normalizer u_mdfeed_normalizer (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .cons_ready(cons_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_side(cmd_side), .cmd_qty(cmd_qty), .cmd_exec_qty(cmd_exec_qty),
    .cmd_cancel_qty(cmd_cancel_qty), .cmd_price(cmd_price), .cmd_symbol(cmd_symbol),
    .cmd_order_id(cmd_order_id)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // consumer ready: 0 always, 1 held low, 2 throttled
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      case (cmode)
        0: cons_ready = 1'b1;
        1: cons_ready = 1'b0;
        default: cons_ready = (cyc % 3 == 2);
      endcase
      cyc++;
    end
  end

  // monitor / scoreboard
  initial begin
    bit taken_prev = 0;
    forever begin
      @(negedge clk); #3;
      if (!rst) begin
        if (!in_ready) stall_cycles++;
        if (taken_prev)
          chk(!cmd_valid, "R11", "valid after take", 64'(cmd_valid), 0);
        taken_prev = 0;
        if (cmd_valid && cons_ready) begin
          exp_t e;
          taken_prev = 1;
          n_cmds++;
          if (sb.size() == 0) begin
            chk(0, "R10", "unexpected command", 64'(cmd_code), 0);
          end else begin
            e = sb.pop_front();
            chk(cmd_code == e.code, e.tag, "code", 64'(cmd_code), 64'(e.code));
            chk(cmd_side == e.side, e.tag, "side", 64'(cmd_side), 64'(e.side));
            chk(cmd_qty == e.qty, "R7", "qty", 64'(cmd_qty), 64'(e.qty));
            chk(cmd_exec_qty == e.xq, e.tag, "exec qty", 64'(cmd_exec_qty), 64'(e.xq));
            chk(cmd_cancel_qty == e.cq, e.tag, "cancel qty", 64'(cmd_cancel_qty), 64'(e.cq));
            chk(cmd_price == e.price, e.tag, "price", cmd_price, e.price);
            chk(cmd_symbol == e.sym, "R8", "symbol", cmd_symbol, e.sym);
            chk(cmd_order_id == e.oid, "R7", "order id", cmd_order_id, e.oid);
          end
        end
      end
    end
  end

  task automatic put_le(ref logic [7:0] m[$], input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) m.push_back(v[8*i +: 8]);
  endtask

  task automatic filler(ref logic [7:0] m[$], input int n);
    for (int i = 0; i < n; i++) m.push_back(8'h5A + 8'(i));
  endtask

  task automatic send_bytes(input logic [7:0] m[$], input int gap);
    for (int i = 0; i < m.size(); i++) begin
      bit acc;
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = m[i];
      forever begin
        #3; acc = in_ready;
        @(posedge clk);
        if (acc) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_cmd(input string tag, input logic [1:0] code, input logic [7:0] side,
                            input logic [31:0] qty, input logic [31:0] xq, input logic [31:0] cq,
                            input logic [63:0] price, input logic [47:0] sym6, input logic [63:0] oid);
    exp_t e;
    e.tag = tag; e.code = code; e.side = side; e.qty = qty; e.xq = xq; e.cq = cq;
    e.price = price; e.sym = {16'h2020, sym6}; e.oid = oid;
    sb.push_back(e);
    n_sent_cmds++;
  endtask

  task automatic msg_long(input logic [63:0] oid, input logic [7:0] side, input logic [31:0] qty,
                          input logic [47:0] sym6, input logic [63:0] price, input int gap);
    logic [7:0] m[$];
    m.push_back(8'd34); m.push_back(8'h21); filler(m, 4);
    put_le(m, oid, 8); m.push_back(side); put_le(m, 64'(qty), 4);
    put_le(m, 64'(sym6), 6); put_le(m, price, 8); filler(m, 1);
    expect_cmd("R3", 2'd1, side, qty, 0, 0, price, sym6, oid);
    send_bytes(m, gap);
  endtask

  task automatic msg_short(input logic [63:0] oid, input logic [7:0] side, input logic [15:0] qty,
                           input logic [47:0] sym6, input logic [15:0] price, input int gap);
    logic [7:0] m[$];
    m.push_back(8'd26); m.push_back(8'h22); filler(m, 4);
    put_le(m, oid, 8); m.push_back(side); put_le(m, 64'(qty), 2);
    put_le(m, 64'(sym6), 6); put_le(m, 64'(price), 2); filler(m, 1);
    expect_cmd("R4", 2'd1, side, 32'(qty), 0, 0, 64'(price) * 64'd100, sym6, oid);
    send_bytes(m, gap);
  endtask

  task automatic msg_exec_cancel(input bit cancel, input logic [63:0] oid,
                                 input logic [31:0] q, input int gap);
    logic [7:0] m[$];
    m.push_back(8'd18); m.push_back(cancel ? 8'h24 : 8'h23); filler(m, 4);
    put_le(m, oid, 8); put_le(m, 64'(q), 4);
    if (cancel) expect_cmd("R6", 2'd3, 0, 0, 0, q, 0, {6{8'h20}}, oid);
    else        expect_cmd("R5", 2'd2, 0, 0, q, 0, 0, {6{8'h20}}, oid);
    send_bytes(m, gap);
  endtask

  task automatic msg_unknown(input logic [7:0] len, input logic [7:0] typ, input int gap);
    logic [7:0] m[$];
    m.push_back(len); m.push_back(typ);
    if (len > 2) filler(m, int'(len) - 2);
    send_bytes(m, gap);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #3;
    chk(cmd_valid == 1'b0, "R1", "valid after reset", 64'(cmd_valid), 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 1);

    // R3 R7 R8: long add with distinct bytes in every lane
    msg_long(64'h0807060504030201, 8'h42, 32'h0A0B0C0D, 48'h464544434241, 64'h1122334455667788, 2);
    drain();

    // R12: back to back, consumer always ready; R9 clearing between kinds
    stall_cycles = 0;
    msg_short(64'h00000000DEADBEEF, 8'h53, 16'h1234, 48'h205A59585756, 16'h0102, 0);
    msg_exec_cancel(0, 64'h0000000000000777, 32'h00000064, 0);
    msg_exec_cancel(1, 64'hFFFFFFFFFFFFFFFF, 32'h80000001, 0);
    msg_long(64'h1, 8'h53, 32'h1, 48'h2020204A4B4C, 64'h5, 0);
    drain();
    chk(stall_cycles == 0, "R12", "in_ready low cycles", 64'(stall_cycles), 0);

    // R10 R2: unknown types, including minimal and sub-minimal lengths
    msg_unknown(8'd12, 8'h37, 0);
    msg_unknown(8'd2, 8'h00, 0);
    msg_unknown(8'd1, 8'h99, 0);
    msg_exec_cancel(1, 64'h0000000012345678, 32'h00000005, 1);
    drain();

    // R4 boundary: widest short quantity and price
    msg_short(64'h2, 8'h42, 16'hFFFF, 48'h414141414141, 16'hFFFF, 1);
    drain();

    // R11: consumer held low, second message waits behind the first command
    cmode = 1;
    fork
      begin
        msg_long(64'hCAFE, 8'h42, 32'd500, 48'h595858585858, 64'd99990000, 0);
        msg_exec_cancel(0, 64'hCAFE, 32'd200, 0);
      end
    join_none
    repeat (80) @(posedge clk);
    @(negedge clk); #3;
    chk(cmd_valid == 1'b1, "R11", "valid held", 64'(cmd_valid), 1);
    chk(in_ready == 1'b0, "R11", "input stalled", 64'(in_ready), 0);
    chk(cmd_order_id == 64'hCAFE, "R11", "held order id", cmd_order_id, 64'hCAFE);
    cmode = 0;
    wait fork;
    drain();

    // throttled consumer
    cmode = 2;
    msg_short(64'h33, 8'h53, 16'h0001, 48'h303132333435, 16'h0000, 0);
    msg_exec_cancel(0, 64'h33, 32'h7, 0);
    msg_unknown(8'd5, 8'hFE, 0);
    msg_long(64'h44, 8'h42, 32'hFFFFFFFF, 48'h202020202020, 64'hFFFFFFFFFFFFFFFF, 0);
    drain();
    cmode = 0;

    chk(sb.size() == 0, "R10", "pending expected", 64'(sb.size()), 0);
    chk(n_cmds == n_sent_cmds, "R10", "command count", 64'(n_cmds), 64'(n_sent_cmds));
    done = 1;
    finish_run();
  end

endmodule